// File: doc/BRIEF.md
# Kernel Stack Limit Zone Checker

This block classifies the kernel stack pointer against a programmable lower bound each time a stack-referencing access is flagged. An address at or above the bound is normal. An address below the bound, but by no more than the red margin, is a warning. The warning lets the current instruction finish and leaves a sticky request for a synchronous trap. An address more than the margin below the bound is fatal. The block then raises a one-cycle abort, supplies a small replacement stack pointer that leaves room for exactly one trap frame, and reports a red cause bit.

The checker does not keep the CPU error register. It presents, for one cycle, the cause bits that the surrounding logic ORs into that register. A warning followed later by a fatal event therefore accumulates both bits there. Checks are ignored while a trap or interrupt frame is being pushed, and while the processor is not in kernel mode. All outputs are registered, and each appears on the clock edge that samples the qualifying strobe.

Top module: `stklim_zone_checker`

## Requirements
- R1: After reset, `yel_pending`, `red_abort`, `red_sp` and `cause_set` are all zero.
- R2: A qualified check with `sp_val < limit_val` (unsigned) and `sp_val + 32 >= limit_val` gives `cause_set = 8'h08` (bit 3) for one cycle and sets `yel_pending` on the same edge.
- R3: A qualified check with `sp_val + 32 < limit_val` gives `red_abort = 1`, `red_sp = 16'h0004` and `cause_set = 8'h04` (bit 2), all for that cycle only.
- R4: A red check does not set `yel_pending`; if it was set already, it remains set.
- R5: A qualified check with `sp_val >= limit_val` produces no cause bits, no abort and no change to `yel_pending`.
- R6: `yel_pending` stays set until `trap_taken` is high at a clock edge. If `trap_taken` arrives together with a new warning, the warning wins and the flag stays set.
- R7: While `frame_push` is high, a check has no effect on any output.
- R8: While `kernel_mode` is low, a check has no effect on any output.
- R9: The sum `sp_val + 32` is formed in 17 bits, so a stack pointer near 16'hFFFF never shows as red. With `chk_en` low, no check takes place.
- R10: On back-to-back qualified red checks, `red_abort` is high on each of those cycles and drops on the first cycle with no red check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chk_en | input | 1 | Strobe: a stack-referencing access occurs this cycle |
| kernel_mode | input | 1 | High when the current mode is kernel |
| frame_push | input | 1 | High while a trap or interrupt frame is being pushed |
| trap_taken | input | 1 | The pending warning trap is being taken; clears the flag |
| sp_val | input | 16 | Current stack pointer |
| limit_val | input | 16 | Programmable stack limit |
| yel_pending | output | 1 | Sticky warning trap request |
| red_abort | output | 1 | One-cycle fatal abort pulse |
| red_sp | output | 16 | Replacement stack pointer, valid with `red_abort`, zero otherwise |
| cause_set | output | 8 | Cause bits to OR into the error register this cycle |

## Verification
The bench uses the default parameters: a 16-bit address, a 32-byte red margin, a forced pointer of 4, and cause bits 3 and 2. With these values the exact edges can be reached with small limit values: one below the limit, exactly 32 below, and 33 below. A stack pointer of 16'hFFF0 against a small limit probes the 17-bit sum. A limit of 16'hFFFF with a pointer of zero probes the far red end.

// File: rtl/stklim_pkg.sv
package stklim_pkg;
  typedef enum logic [1:0] {
    ZONE_OK     = 2'd0,
    ZONE_YELLOW = 2'd1,
    ZONE_RED    = 2'd2
  } zone_e;
endpackage

// File: rtl/stklim_rst_sync.sv
module stklim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/stklim_classify.sv
module stklim_classify
  import stklim_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RED_MARGIN = 32
) (
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] limit_val,
  output zone_e             zone
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] sp_ext, lim_ext, sp_plus_margin;

  always_comb begin
    sp_ext         = {1'b0, sp_val};
    lim_ext        = {1'b0, limit_val};
    sp_plus_margin = sp_ext + SUM_W'(RED_MARGIN);
    if (sp_plus_margin < lim_ext)  zone = ZONE_RED;
    else if (sp_ext < lim_ext)     zone = ZONE_YELLOW;
    else                           zone = ZONE_OK;
  end
endmodule

// File: rtl/stklim_pending.sv
module stklim_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d, pend_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6: flag held unless cleared without a concurrent set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) && !$past(clr_i)) |-> pend_q);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_q);
endmodule

// File: rtl/stklim_report.sv
module stklim_report
  import stklim_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CAUSE_W = 8,
  parameter int YEL_BIT = 3,
  parameter int RED_BIT = 2,
  parameter int RED_SP  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_q,
  input  zone_e              zone,
  output logic               yel_event,
  output logic               red_abort,
  output logic [ADDR_W-1:0]  red_sp,
  output logic [CAUSE_W-1:0] cause_set
);
  logic               red_d, red_q;
  logic [ADDR_W-1:0]  sp_d, sp_q;
  logic [CAUSE_W-1:0] cause_d, cause_q;

  always_comb begin
    red_d     = chk_q && (zone == ZONE_RED);
    yel_event = chk_q && (zone == ZONE_YELLOW);
    cause_d   = '0;
    for (int b = 0; b < CAUSE_W; b++) begin
      if (b == RED_BIT) cause_d[b] = red_d;
      if (b == YEL_BIT) cause_d[b] = yel_event;
    end
    sp_d = red_d ? ADDR_W'(RED_SP) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_q   <= 1'b0;
      sp_q    <= '0;
      cause_q <= '0;
    end else begin
      red_q   <= red_d;
      sp_q    <= sp_d;
      cause_q <= cause_d;
    end
  end

  assign red_abort = red_q;
  assign red_sp    = sp_q;
  assign cause_set = cause_q;

  // R3: a red check yields the abort, forced pointer and red cause together
  a_r3_red_bundle: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_q && zone == ZONE_RED) |=>
      (red_abort && red_sp == ADDR_W'(RED_SP) && $countones(cause_set) == 1 && cause_set[RED_BIT]));
  // R10: abort drops when no red check was sampled
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_q && zone == ZONE_RED) |=> !red_abort);
endmodule

// File: rtl/stklim_zone_checker.sv
module stklim_zone_checker
  import stklim_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RED_MARGIN = 32,
  parameter int RED_SP     = 4,
  parameter int CAUSE_W    = 8,
  parameter int YEL_BIT    = 3,
  parameter int RED_BIT    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_en,
  input  logic               kernel_mode,
  input  logic               frame_push,
  input  logic               trap_taken,
  input  logic [ADDR_W-1:0]  sp_val,
  input  logic [ADDR_W-1:0]  limit_val,
  output logic               yel_pending,
  output logic               red_abort,
  output logic [ADDR_W-1:0]  red_sp,
  output logic [CAUSE_W-1:0] cause_set
);
  logic  rst_n_s;
  logic  chk_q;
  logic  yel_event;
  zone_e zone;

  stklim_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign chk_q = chk_en && kernel_mode && !frame_push;

  stklim_classify #(.ADDR_W(ADDR_W), .RED_MARGIN(RED_MARGIN)) u_cls (
    .sp_val(sp_val), .limit_val(limit_val), .zone(zone)
  );

  stklim_report #(
    .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .YEL_BIT(YEL_BIT),
    .RED_BIT(RED_BIT), .RED_SP(RED_SP)
  ) u_rep (
    .clk(clk), .rst_n(rst_n_s), .chk_q(chk_q), .zone(zone),
    .yel_event(yel_event), .red_abort(red_abort),
    .red_sp(red_sp), .cause_set(cause_set)
  );

  stklim_pending u_pend (
    .clk(clk), .rst_n(rst_n_s), .set_i(yel_event),
    .clr_i(trap_taken), .pend_o(yel_pending)
  );

  // R2: warning cause is always accompanied by the pending flag
  a_r2_cause_sets_pending: assert property (@(posedge clk) disable iff (!rst_n_s)
    cause_set[YEL_BIT] |-> yel_pending);
  // R4: a red event never raises the pending flag from clear
  a_r4_red_no_pending: assert property (@(posedge clk) disable iff (!rst_n_s)
    (red_abort && !$past(yel_pending)) |-> !yel_pending);
  // R7: frame push silences the checker
  a_r7_push_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_push |=> (cause_set == '0 && !red_abort));
  // R8: non-kernel accesses are not checked
  a_r8_user_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !kernel_mode |=> (cause_set == '0 && !red_abort));
endmodule

// File: tb/stklim_zone_checker_tb_top.sv
`timescale 1ns/1ps
module stklim_zone_checker_tb_top;
  logic        clk, rst_n;
  logic        chk_en, kernel_mode, frame_push, trap_taken;
  logic [15:0] sp_val, limit_val;
  logic        yel_pending, red_abort;
  logic [15:0] red_sp;
  logic [7:0]  cause_set;

  typedef struct packed {
    logic        red;
    logic [15:0] sp;
    logic [7:0]  cause;
    logic        pend;
    logic [3:0]  req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  logic model_pend;
  bit   done = 0;

  stklim_zone_checker dut_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .kernel_mode(kernel_mode),
    .frame_push(frame_push), .trap_taken(trap_taken), .sp_val(sp_val),
    .limit_val(limit_val), .yel_pending(yel_pending), .red_abort(red_abort),
    .red_sp(red_sp), .cause_set(cause_set)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic step(input logic c, input logic [15:0] sp, input logic [15:0] lim,
                      input logic k, input logic p, input logic t, input logic [3:0] req);
    exp_t e;
    int   s, l;
    @(negedge clk);
    chk_en = c; sp_val = sp; limit_val = lim;
    kernel_mode = k; frame_push = p; trap_taken = t;
    s = int'(sp); l = int'(lim);
    e = '0; e.req = req;
    if (c && k && !p) begin
      if (s + 32 < l) begin
        e.red = 1; e.sp = 16'd4; e.cause = 8'h04;
      end else if (s < l) begin
        e.cause = 8'h08;
      end
    end
    if (t) model_pend = 0;
    if (e.cause == 8'h08) model_pend = 1;
    e.pend = model_pend;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_chk++;
      if (red_abort !== e.red || red_sp !== e.sp || cause_set !== e.cause || yel_pending !== e.pend) begin
        n_bad++;
        $display("FAIL R%0d: got red=%0b sp=%h cause=%h pend=%0b exp red=%0b sp=%h cause=%h pend=%0b",
                 e.req, red_abort, red_sp, cause_set, yel_pending, e.red, e.sp, e.cause, e.pend);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_pend = 0;
    rst_n = 0; chk_en = 0; kernel_mode = 1; frame_push = 0; trap_taken = 0;
    sp_val = 16'h1000; limit_val = 16'h0400;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_chk++;  // R1 reset state
    if (red_abort !== 0 || red_sp !== 0 || cause_set !== 0 || yel_pending !== 0) begin
      n_bad++;
      $display("FAIL R1: got red=%0b sp=%h cause=%h pend=%0b exp all zero",
               red_abort, red_sp, cause_set, yel_pending);
    end
    step(0, 16'h1000, 16'h0400, 1, 0, 0, 1);
    step(1, 16'h03FE, 16'h0400, 1, 0, 0, 2);   // R2 yellow
    step(0, 16'h03FE, 16'h0400, 1, 0, 0, 6);   // R6 held
    step(0, 16'h03FE, 16'h0400, 1, 0, 1, 6);   // R6 cleared
    step(1, 16'h0400, 16'h0400, 1, 0, 0, 5);   // R5 at limit
    step(1, 16'h03E0, 16'h0400, 1, 0, 0, 2);   // R2 edge: exactly 32 below
    step(0, 16'h0000, 16'h0400, 1, 0, 1, 6);
    step(1, 16'h03DF, 16'h0400, 1, 0, 0, 3);   // R3 red, R4 no pending
    step(0, 16'h03DF, 16'h0400, 1, 0, 0, 10);  // R10 pulse ends
    step(1, 16'h03F0, 16'h0400, 1, 0, 0, 2);
    step(1, 16'h0100, 16'h0400, 1, 0, 0, 4);   // R4 red keeps pending set
    step(1, 16'h0100, 16'h0400, 1, 1, 0, 7);   // R7 frame push
    step(1, 16'h03FF, 16'h0400, 1, 1, 1, 7);   // R7 push, clear works
    step(1, 16'h0100, 16'h0400, 0, 0, 0, 8);   // R8 user mode red
    step(1, 16'h03FF, 16'h0400, 0, 0, 0, 8);   // R8 user mode yellow
    step(1, 16'hFFF0, 16'h0010, 1, 0, 0, 9);   // R9 no wrap
    step(1, 16'hFFFF, 16'hFFFF, 1, 0, 0, 9);
    step(1, 16'h0000, 16'h0010, 1, 0, 0, 2);
    step(1, 16'h0000, 16'hFFFF, 1, 0, 1, 3);   // R3 far red, clear
    step(0, 16'h0000, 16'hFFFF, 1, 0, 0, 9);   // R9 strobe low
    step(1, 16'h03F8, 16'h0400, 1, 0, 1, 6);   // R6 set wins over clear
    step(0, 16'h0000, 16'h0400, 1, 0, 0, 6);
    step(1, 16'h0010, 16'h0400, 1, 0, 1, 10);  // R10 back to back
    step(1, 16'h0020, 16'h0400, 1, 0, 0, 10);
    step(1, 16'h0030, 16'h0400, 1, 0, 0, 10);
    step(1, 16'h0800, 16'h0400, 1, 0, 0, 10);
    step(0, 16'h0800, 16'h0400, 1, 0, 0, 5);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule